// File: doc/BRIEF.md
# Interrupt Message Request Generator

This block watches a set of interrupt input lines, one per source, and turns each active line into an interrupt request message on a valid/ready output channel. Each source has its own configuration: a mask, an input polarity, a request-end-of-interrupt enable, a pass-posted-write flag and an information word. The information word holds the message type in bits [4:2] and the address bits in [31:24]. An outgoing message carries the source number, that source's information word and its pass-posted-write flag.

A source can ask for an end-of-interrupt handshake. When that is enabled, accepting a message from the source sets the source's waiting status bit. The source is then held off until an incoming end-of-interrupt for that source, or a software write-1 clear, removes the bit. The sources are level sensitive, so a line that is still active once it becomes eligible again is requested again.

The control is a two-state machine. In `ST_IDLE` nothing is offered; the transition `GO_OFFER` is taken when at least one source is eligible. It captures the lowest-numbered eligible source into the payload registers. In `ST_OFFER` the payload is presented with valid high; the transition `GO_IDLE` is taken when ready is high, and `HOLD` keeps the state otherwise.

Top module: `irq_msg_gen`

## Requirements
- R1: A source whose mask bit is 1 is never captured for a message.
- R2: Polarity bit 1 makes the source active when its input is 0; polarity bit 0 makes it active when its input is 1.
- R3: A source is captured with its request-EOI bit as it stands at that moment. If that bit was 1, the accepting handshake sets the source's wait_eoi bit at that clock edge. While a source's request-EOI bit and wait_eoi bit are both 1, it is not captured.
- R4: eoi_valid with eoi_src = k clears wait_eoi[k] at the next edge, and sw_clr[k] = 1 does the same. If a set and a clear for the same source fall in the same cycle, the set wins.
- R5: While a source's request-EOI bit is 0, its wait_eoi bit does not stop it from being captured.
- R6: msg_src is the source number. msg_info is that source's cfg_info slice, bits [k*INFO_W +: INFO_W]. msg_passpw is that source's cfg_passpw bit, all as sampled at the capture edge.
- R7: When several sources are eligible in the same idle cycle, the lowest-numbered one is captured.
- R8: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and msg_src, msg_info and msg_passpw do not change.
- R9: A source that is eligible in an idle cycle is offered with msg_valid = 1 after the next edge. After a handshake, msg_valid is 0 for exactly one cycle before the next capture can show.
- R10: A source with request-EOI enabled whose input is still active is offered again once its wait_eoi bit has been cleared.
- R11: Clearing the mask bit of a source whose input is already active gets it offered after the next edge, provided the machine is idle and no lower source is eligible.
- R12: After reset, msg_valid is 0 and every wait_eoi bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Raw interrupt lines, one per source |
| cfg_mask | input | NUM_SRC | 1 = source suppressed |
| cfg_pol | input | NUM_SRC | 1 = active low, 0 = active high |
| cfg_eoi_req | input | NUM_SRC | 1 = source waits for end-of-interrupt after each message |
| cfg_passpw | input | NUM_SRC | Pass-posted-write flag copied into the message |
| cfg_info | input | NUM_SRC*INFO_W | Information words, source k at [k*INFO_W +: INFO_W] |
| eoi_valid | input | 1 | Incoming end-of-interrupt strobe |
| eoi_src | input | SRC_W | Source addressed by the end-of-interrupt |
| sw_clr | input | NUM_SRC | Software write-1 clear of wait_eoi bits |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_src | output | SRC_W | Source number of the offered message |
| msg_info | output | INFO_W | Information word of the offered message |
| msg_passpw | output | 1 | Pass-posted-write flag of the offered message |
| wait_eoi | output | NUM_SRC | Waiting-for-EOI status per source |

## Verification
Every result is due exactly one rising edge after the inputs that cause it are sampled. A capture shows as msg_valid with payload, a handshake sets a wait_eoi bit, and an EOI or a software clear drops one. A freed source therefore shows as a new offer two edges after the clear: one edge for the status bit and one for the capture. Stimulus changes on falling edges. A reference model written from the requirements updates on the rising edge, and the outputs are compared on the following falling edge. The directed checks count edges the same way before they compare against fixed expected values.

// File: rtl/irq_msg_gen_pkg.sv
package irq_msg_gen_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } gen_state_e;
endpackage

// File: rtl/irq_msg_gen_qualify.sv
module irq_msg_gen_qualify #(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] cfg_mask,
    input  logic [NUM_SRC-1:0] cfg_pol,
    input  logic [NUM_SRC-1:0] cfg_eoi_req,
    input  logic [NUM_SRC-1:0] wait_eoi,
    output logic [NUM_SRC-1:0] eligible
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic active;
        logic blocked;
        // polarity 1 = active low (R2)
        assign active      = irq_in[g] ^ cfg_pol[g];
        // EOI wait only matters when request-EOI is enabled (R3, R5)
        assign blocked     = cfg_eoi_req[g] & wait_eoi[g];
        assign eligible[g] = active & ~cfg_mask[g] & ~blocked;
    end
endmodule

// File: rtl/irq_msg_gen_prio.sv
module irq_msg_gen_prio #(
    parameter int NUM_SRC = 4,
    parameter int SRC_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  req,
    output logic                any,
    output logic [SRC_W-1:0]    pick
);
    always_comb begin
        pick = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) pick = SRC_W'(i);
        end
    end
    assign any = |req;

    // lowest-numbered request wins (R7)
    assert_lowest_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (req[pick] && ((req & ((NUM_SRC'(1) << pick) - NUM_SRC'(1))) == '0)));
endmodule

// File: rtl/irq_msg_gen_eoi_track.sv
module irq_msg_gen_eoi_track #(
    parameter int NUM_SRC = 4,
    parameter int SRC_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  set_vec,
    input  logic                eoi_valid,
    input  logic [SRC_W-1:0]    eoi_src,
    input  logic [NUM_SRC-1:0]  sw_clr,
    output logic [NUM_SRC-1:0]  wait_eoi
);
    logic [NUM_SRC-1:0] eoi_oh;
    logic [NUM_SRC-1:0] clr_vec;

    assign eoi_oh  = eoi_valid ? (NUM_SRC'(1) << eoi_src) : '0;
    assign clr_vec = sw_clr | eoi_oh;

    // set has priority over a same-cycle clear (R4)
    always_ff @(posedge clk) begin
        if (!rst_n) wait_eoi <= '0;
        else        wait_eoi <= (wait_eoi & ~clr_vec) | set_vec;
    end

    assert_eoi_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && ((eoi_oh & set_vec) == '0)) |=> ((wait_eoi & $past(eoi_oh)) == '0));
endmodule

// File: rtl/irq_msg_gen.sv
module irq_msg_gen
    import irq_msg_gen_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int INFO_W  = 32,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         irq_in,
    input  logic [NUM_SRC-1:0]         cfg_mask,
    input  logic [NUM_SRC-1:0]         cfg_pol,
    input  logic [NUM_SRC-1:0]         cfg_eoi_req,
    input  logic [NUM_SRC-1:0]         cfg_passpw,
    input  logic [NUM_SRC*INFO_W-1:0]  cfg_info,
    input  logic                       eoi_valid,
    input  logic [SRC_W-1:0]           eoi_src,
    input  logic [NUM_SRC-1:0]         sw_clr,
    output logic                       msg_valid,
    input  logic                       msg_ready,
    output logic [SRC_W-1:0]           msg_src,
    output logic [INFO_W-1:0]          msg_info,
    output logic                       msg_passpw,
    output logic [NUM_SRC-1:0]         wait_eoi
);
    gen_state_e         state_q, state_d;
    logic [NUM_SRC-1:0] eligible;
    logic               any_elig;
    logic [SRC_W-1:0]   pick_idx;
    logic               load_msg;
    logic               handshake;
    logic [SRC_W-1:0]   src_q;
    logic [INFO_W-1:0]  info_q;
    logic               pw_q;
    logic               eoi_q;
    logic [NUM_SRC-1:0] src_oh;
    logic [NUM_SRC-1:0] set_vec;

    irq_msg_gen_qualify #(.NUM_SRC(NUM_SRC)) u_qualify (
        .irq_in      (irq_in),
        .cfg_mask    (cfg_mask),
        .cfg_pol     (cfg_pol),
        .cfg_eoi_req (cfg_eoi_req),
        .wait_eoi    (wait_eoi),
        .eligible    (eligible)
    );

    irq_msg_gen_prio #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (eligible),
        .any   (any_elig),
        .pick  (pick_idx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: GO_OFFER, GO_IDLE, HOLD
    always_comb begin
        state_d  = state_q;
        load_msg = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_elig) begin
                    state_d  = ST_OFFER;
                    load_msg = 1'b1;
                end
            end
            ST_OFFER: begin
                if (msg_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        msg_valid  = (state_q == ST_OFFER);
        handshake  = msg_valid && msg_ready;
        msg_src    = src_q;
        msg_info   = info_q;
        msg_passpw = pw_q;
    end

    // payload capture (R6), held through the offer (R8)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            info_q <= '0;
            pw_q   <= 1'b0;
            eoi_q  <= 1'b0;
        end else if (load_msg) begin
            src_q  <= pick_idx;
            info_q <= cfg_info[pick_idx*INFO_W +: INFO_W];
            pw_q   <= cfg_passpw[pick_idx];
            eoi_q  <= cfg_eoi_req[pick_idx];
        end
    end

    assign src_oh  = NUM_SRC'(1) << src_q;
    assign set_vec = (handshake && eoi_q) ? src_oh : '0;

    irq_msg_gen_eoi_track #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_eoi (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .eoi_valid (eoi_valid),
        .eoi_src   (eoi_src),
        .sw_clr    (sw_clr),
        .wait_eoi  (wait_eoi)
    );

    assert_payload_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_src)
                                       && $stable(msg_info) && $stable(msg_passpw)));

    assert_gap_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);

    assert_masked_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> (($past(cfg_mask) & src_oh) == '0));

    assert_eoi_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> (($past(cfg_eoi_req & wait_eoi) & src_oh) == '0));

    assert_status_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (handshake && eoi_q) |=> ((wait_eoi & $past(src_oh)) != '0));
endmodule

// File: tb/irq_msg_gen_bench.sv
module irq_msg_gen_bench;
    localparam int N  = 4;
    localparam int IW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    irq_in = '0, cfg_mask = '1, cfg_pol = '0, cfg_eoi_req = '0, cfg_passpw = '0;
    logic [N*IW-1:0] cfg_info = '0;
    logic            eoi_valid = 1'b0;
    logic [1:0]      eoi_src = '0;
    logic [N-1:0]    sw_clr = '0;
    logic            msg_valid, msg_ready = 1'b0, msg_passpw;
    logic [1:0]      msg_src;
    logic [IW-1:0]   msg_info;
    logic [N-1:0]    wait_eoi;

    int tests = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_msg_gen #(.NUM_SRC(N), .INFO_W(IW)) u_irq_msg_gen (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_mask(cfg_mask), .cfg_pol(cfg_pol),
        .cfg_eoi_req(cfg_eoi_req), .cfg_passpw(cfg_passpw), .cfg_info(cfg_info),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .sw_clr(sw_clr), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_src(msg_src), .msg_info(msg_info),
        .msg_passpw(msg_passpw), .wait_eoi(wait_eoi)
    );

    function automatic logic [IW-1:0] info_of(int i);
        return 32'hF800_0000 | (32'(i) << 16) | (32'(i) << 2);
    endfunction

    function automatic int lowest(logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic logic [N-1:0] eligible_of(logic [N-1:0] irq, logic [N-1:0] msk,
            logic [N-1:0] pol, logic [N-1:0] er, logic [N-1:0] wt);
        return (irq ^ pol) & ~msk & ~(er & wt);
    endfunction

    // reference model built from the requirements
    logic          m_busy, m_pw, m_eflag;
    logic [1:0]    m_src;
    logic [IW-1:0] m_info;
    logic [N-1:0]  m_wait, m_e, m_set, m_clr;
    int            m_lo;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_src <= 0; m_info <= 0; m_pw <= 0; m_eflag <= 0; m_wait <= 0;
        end else begin
            m_e   = eligible_of(irq_in, cfg_mask, cfg_pol, cfg_eoi_req, m_wait);
            m_set = (m_busy && msg_ready && m_eflag) ? (N'(1) << m_src) : '0;
            m_clr = sw_clr | (eoi_valid ? (N'(1) << eoi_src) : '0);
            m_wait <= (m_wait & ~m_clr) | m_set;
            if (!m_busy) begin
                if (m_e != 0) begin
                    m_lo = lowest(m_e);
                    m_busy <= 1; m_src <= 2'(m_lo);
                    m_info <= cfg_info[m_lo*IW +: IW];
                    m_pw <= cfg_passpw[m_lo]; m_eflag <= cfg_eoi_req[m_lo];
                end
            end else if (msg_ready) m_busy <= 0;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_model(string tag);
        chk(tag, 64'(msg_valid), 64'(m_busy));
        chk(tag, 64'(wait_eoi), 64'(m_wait));
        if (m_busy) begin
            chk(tag, 64'(msg_src), 64'(m_src));
            chk(tag, 64'(msg_info), 64'(m_info));
            chk(tag, 64'(msg_passpw), 64'(m_pw));
        end
    endtask

    task automatic tick(string tag);
        @(posedge clk); @(negedge clk);
        cmp_model(tag);
    endtask

    initial begin
        int r;
        r = $urandom(32'd1234);
        for (int i = 0; i < N; i++) cfg_info[i*IW +: IW] = info_of(i);
        cfg_passpw = 4'b0100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R12 valid", 64'(msg_valid), 0);
        chk("R12 wait", 64'(wait_eoi), 0);

        // R1: all masked, all active
        irq_in = 4'b1111; cfg_eoi_req = 4'b1111; msg_ready = 0;
        tick("R1"); tick("R1");
        chk("R1 masked", 64'(msg_valid), 0);

        // R7 / R11: unmask 2 and 3 together
        cfg_mask = 4'b0011;
        tick("R11");
        chk("R11 valid", 64'(msg_valid), 1);
        chk("R7 src", 64'(msg_src), 2);
        chk("R6 info", 64'(msg_info), 64'(info_of(2)));
        chk("R6 passpw", 64'(msg_passpw), 1);

        // R8: hold
        tick("R8"); tick("R8"); tick("R8");
        chk("R8 held", 64'(msg_src), 2);
        chk("R8 valid", 64'(msg_valid), 1);

        // R3 / R9
        msg_ready = 1;
        tick("R9");
        chk("R9 gap", 64'(msg_valid), 0);
        chk("R3 set", 64'(wait_eoi), 4'b0100);
        tick("R7");
        chk("R7 next", 64'(msg_src), 3);
        chk("R6 passpw3", 64'(msg_passpw), 0);
        tick("R3");
        chk("R3 set3", 64'(wait_eoi), 4'b1100);
        tick("R3"); tick("R3");
        chk("R3 blocked", 64'(msg_valid), 0);

        // R4 / R10: EOI for source 2
        eoi_valid = 1; eoi_src = 2;
        tick("R4");
        chk("R4 eoi", 64'(wait_eoi), 4'b1000);
        eoi_valid = 0;
        tick("R10");
        chk("R10 reoffer", 64'(msg_valid), 1);
        chk("R10 src", 64'(msg_src), 2);
        tick("R3");

        // R4: software clear of source 3
        sw_clr = 4'b1000;
        tick("R4");
        chk("R4 swclr", 64'(wait_eoi), 4'b0100);
        sw_clr = 0; msg_ready = 0;
        tick("R10");
        chk("R10 src3", 64'(msg_src), 3);
        msg_ready = 1;
        tick("R3");
        chk("R3 set again", 64'(wait_eoi), 4'b1100);

        // R5: request-EOI off for source 3, wait bit still set
        cfg_eoi_req = 4'b0111;
        tick("R5");
        chk("R5 valid", 64'(msg_valid), 1);
        chk("R5 src", 64'(msg_src), 3);
        chk("R5 wait kept", 64'(wait_eoi[3]), 1);

        // R2: polarity on source 0
        cfg_mask = 4'b1111;
        tick("R2"); tick("R2");
        cfg_pol = 4'b0001; irq_in = 4'b1111; cfg_mask = 4'b1110;
        tick("R2"); tick("R2");
        chk("R2 inactive high", 64'(msg_valid), 0);
        irq_in = 4'b1110;
        tick("R2");
        chk("R2 active low", 64'(msg_valid), 1);
        chk("R2 src", 64'(msg_src), 0);

        // random phase
        for (int c = 0; c < 4000; c++) begin
            if (c % 50 == 0) begin
                cfg_mask    = 4'($urandom) & 4'($urandom);
                cfg_pol     = 4'($urandom);
                cfg_eoi_req = 4'($urandom);
                cfg_passpw  = 4'($urandom);
                for (int i = 0; i < N; i++) cfg_info[i*IW +: IW] = $urandom;
            end
            irq_in    = 4'($urandom);
            msg_ready = ($urandom % 4) != 0;
            eoi_valid = ($urandom % 5) == 0;
            eoi_src   = 2'($urandom);
            sw_clr    = (($urandom % 16) == 0) ? 4'($urandom) : '0;
            tick("R6/R7");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule